// File: doc/BRIEF.md
# Trimmable VLIW Operand and Result Crossbar

This block is the routing fabric between a multi-ported register file and three functional units in a wide-issue datapath. Six operand selectors each pick one of the four register read ports for one of the two inputs of a functional unit. Three result selectors each pick which functional-unit output drives one register write port. Each selector takes a one-hot select vector from the schedule, and routing is purely combinational.

Each source-to-destination connection, or link, is present or removed through a build-time mask. A removed link is absent from its selector. A result selector left with one source becomes a plain wire.

Each link has a saturating counter. It counts the cycles on which that link was selected while its destination was enabled. After running an application, the counters are read out one at a time to find links that were never used, which can then be masked away in the next build. A sticky error flag records any enabled selection that is not one-hot or that names a removed link.

Top module: `vliw_link_xbar`

## Requirements
- R1: Operand selector o (0..5) driven with a one-hot `opnd_sel[o*4 +: 4]` whose bit r is a present link outputs read port r on `opnd_data[o*16 +: 16]` in the same cycle. Operand o feeds unit o/2, input o%2.
- R2: Result selector w (0..2) driven with a one-hot `wr_sel[w*3 +: 3]` whose bit f is a present link outputs `fu_res[f*16 +: 16]` on `wr_data[w*16 +: 16]` in the same cycle.
- R3: With default parameters every link is present, so every read port reaches every operand and every unit output reaches every write port.
- R4: A selector that still has two or more sources outputs zero when its one-hot select names a removed link. Link presence is bit `o*4+r` of `OP_MASK` and bit `w*3+f` of `WR_MASK` (1 = present).
- R5: A result selector with exactly one present source outputs that source whatever its select vector holds.
- R6: If a destination's enable is high while its select vector is not one-hot or names a removed link, `sel_err` goes high at the next rising edge. It stays high until reset. Enabled one-hot selections of present links, and any selection with the enable low, leave it low.
- R7: A link's counter increments by one at each rising edge where its select bit and its destination enable are both high. Operand link o,r has index o*4+r. Result link w,f has index 24+w*3+f.
- R8: A link whose destination enable is low does not count, even when selected.
- R9: Counters saturate at their all-ones value (CW bits wide).
- R10: `cnt_clr` zeroes every counter at the next rising edge and overrides a coincident increment.
- R11: `cnt_val` shows the counter at index `cnt_idx` combinationally. It reads zero for an index of 33 or more and for any removed link.
- R12: During reset `sel_err` is low and every counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_data | input | NRD*DW | Register read-port values, port r at bits r*DW |
| opnd_sel | input | 2*NFU*NRD | One-hot read-port select per operand |
| opnd_en | input | 2*NFU | Operand consumed this cycle |
| opnd_data | output | 2*NFU*DW | Operand values to the functional units |
| fu_res | input | NFU*DW | Functional-unit results |
| wr_sel | input | NWR*NFU | One-hot unit select per write port |
| wr_en | input | NWR | Write port active this cycle |
| wr_data | output | NWR*DW | Values to the write ports |
| sel_err | output | 1 | Sticky illegal-selection flag |
| cnt_clr | input | 1 | Synchronous clear of all link counters |
| cnt_idx | input | IW | Link index for readout |
| cnt_val | output | CW | Counter value of the indexed link |

## Verification
Routed data on `opnd_data` and `wr_data`, and the `cnt_val` readout, are combinational. They are due in the cycle the select or index is applied. The bench changes inputs on the falling edge and samples one time unit later. Counter updates and `sel_err` pass through one register, so they appear after the next rising edge. The bench drives the enables for a known number of falling edges, which fixes the number of rising edges that count. It reads the result after the falling edge that follows. A second, trimmed instance with 4-bit counters covers removed links, the single-source wire and saturation within a few cycles.

// File: rtl/vliw_link_xbar.sv
module vliw_link_xbar #(
  parameter int DW  = 16,
  parameter int NRD = 4,
  parameter int NFU = 3,
  parameter int NWR = 3,
  parameter int CW  = 16,
  parameter logic [2*NFU*NRD-1:0] OP_MASK = '1,
  parameter logic [NWR*NFU-1:0]   WR_MASK = '1,
  localparam int NLINK = 2*NFU*NRD + NWR*NFU,
  localparam int IW = $clog2(NLINK)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NRD*DW-1:0]     rd_data,
  input  logic [2*NFU*NRD-1:0]  opnd_sel,
  input  logic [2*NFU-1:0]      opnd_en,
  output logic [2*NFU*DW-1:0]   opnd_data,
  input  logic [NFU*DW-1:0]     fu_res,
  input  logic [NWR*NFU-1:0]    wr_sel,
  input  logic [NWR-1:0]        wr_en,
  output logic [NWR*DW-1:0]     wr_data,
  output logic                  sel_err,
  input  logic                  cnt_clr,
  input  logic [IW-1:0]         cnt_idx,
  output logic [CW-1:0]         cnt_val
);
  localparam int NOP  = 2*NFU;
  localparam int NOPL = NOP*NRD;
  localparam logic [NLINK-1:0] LMASK = {WR_MASK, OP_MASK};
  localparam logic [IW-1:0] LAST = IW'(NLINK-1);

  function automatic int first_set(input logic [NFU-1:0] m);
    for (int i = NFU-1; i >= 0; i--) if (m[i]) first_set = i;
  endfunction

  always_comb begin
    opnd_data = '0;
    for (int o = 0; o < NOP; o++)
      for (int r = 0; r < NRD; r++)
        if (OP_MASK[o*NRD+r] && opnd_sel[o*NRD+r])
          opnd_data[o*DW +: DW] |= rd_data[r*DW +: DW];
  end

  for (genvar w = 0; w < NWR; w++) begin : g_res
    logic [DW-1:0] res;
    if ($countones(WR_MASK[w*NFU +: NFU]) == 1) begin : g_wire
      assign res = fu_res[first_set(WR_MASK[w*NFU +: NFU])*DW +: DW];
    end else begin : g_mux
      always_comb begin
        res = '0;
        for (int f = 0; f < NFU; f++)
          if (WR_MASK[w*NFU+f] && wr_sel[w*NFU+f]) res |= fu_res[f*DW +: DW];
      end
    end
    assign wr_data[w*DW +: DW] = res;
  end

  logic bad;
  always_comb begin
    bad = 1'b0;
    for (int o = 0; o < NOP; o++)
      if (opnd_en[o] && (!$onehot(opnd_sel[o*NRD +: NRD]) ||
          |(opnd_sel[o*NRD +: NRD] & ~OP_MASK[o*NRD +: NRD]))) bad = 1'b1;
    for (int w = 0; w < NWR; w++)
      if (wr_en[w] && (!$onehot(wr_sel[w*NFU +: NFU]) ||
          |(wr_sel[w*NFU +: NFU] & ~WR_MASK[w*NFU +: NFU]))) bad = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sel_err <= 1'b0;
    else        sel_err <= sel_err | bad;

  logic [NLINK-1:0] go;
  for (genvar l = 0; l < NOPL; l++) begin : g_go_op
    assign go[l] = opnd_sel[l] & opnd_en[l/NRD] & LMASK[l];
  end
  for (genvar k = 0; k < NWR*NFU; k++) begin : g_go_wr
    assign go[NOPL+k] = wr_sel[k] & wr_en[k/NFU] & LMASK[NOPL+k];
  end

  logic [CW-1:0] cnt [NLINK];
  for (genvar l = 0; l < NLINK; l++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                    cnt[l] <= '0;
      else if (cnt_clr)              cnt[l] <= '0;
      else if (go[l] && ~&cnt[l])    cnt[l] <= cnt[l] + 1'b1;
  end

  assign cnt_val = (cnt_idx <= LAST) ? cnt[cnt_idx] : '0;
endmodule

// File: rtl/vliw_link_xbar_chk.sv
module vliw_link_xbar_chk #(
  parameter int DW  = 16,
  parameter int NRD = 4,
  parameter int NFU = 3,
  parameter int NWR = 3,
  parameter int CW  = 16,
  parameter logic [2*NFU*NRD-1:0] OP_MASK = '1,
  parameter logic [NWR*NFU-1:0]   WR_MASK = '1,
  parameter int IW = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NRD*DW-1:0]     rd_data,
  input logic [2*NFU*NRD-1:0]  opnd_sel,
  input logic [2*NFU-1:0]      opnd_en,
  input logic [2*NFU*DW-1:0]   opnd_data,
  input logic [NFU*DW-1:0]     fu_res,
  input logic [NWR*NFU-1:0]    wr_sel,
  input logic [NWR-1:0]        wr_en,
  input logic [NWR*DW-1:0]     wr_data,
  input logic                  sel_err,
  input logic                  cnt_clr,
  input logic [IW-1:0]         cnt_idx,
  input logic [CW-1:0]         cnt_val
);
  for (genvar o = 0; o < 2*NFU; o++) begin : g_op
    for (genvar r = 0; r < NRD; r++) begin : g_src
      if (OP_MASK[o*NRD+r]) begin : g_on
        assert_opnd_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
          (opnd_sel[o*NRD+r] && $onehot(opnd_sel[o*NRD +: NRD])) |->
            opnd_data[o*DW +: DW] == rd_data[r*DW +: DW]);
      end else begin : g_off
        assert_opnd_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
          (opnd_sel[o*NRD+r] && $onehot(opnd_sel[o*NRD +: NRD])) |->
            opnd_data[o*DW +: DW] == '0);
      end
    end
  end

  for (genvar w = 0; w < NWR; w++) begin : g_wr
    for (genvar f = 0; f < NFU; f++) begin : g_src
      if ($countones(WR_MASK[w*NFU +: NFU]) == 1) begin : g_one
        if (WR_MASK[w*NFU+f]) begin : g_wire
          assert_res_wire_R5: assert property (@(posedge clk) disable iff (!rst_n)
            wr_data[w*DW +: DW] == fu_res[f*DW +: DW]);
        end
      end else if (WR_MASK[w*NFU+f]) begin : g_on
        assert_res_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_sel[w*NFU+f] && $onehot(wr_sel[w*NFU +: NFU])) |->
            wr_data[w*DW +: DW] == fu_res[f*DW +: DW]);
      end else begin : g_off
        assert_res_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_sel[w*NFU+f] && $onehot(wr_sel[w*NFU +: NFU])) |->
            wr_data[w*DW +: DW] == '0);
      end
    end
  end

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |=> sel_err);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> cnt_val == '0);

  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_clr) && $stable(cnt_idx)) |->
      (cnt_val == $past(cnt_val) || cnt_val == $past(cnt_val) + 1'b1));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_clr) && $past(opnd_en) == '0 && $past(wr_en) == '0 && $stable(cnt_idx))
      |-> cnt_val == $past(cnt_val));
endmodule

bind vliw_link_xbar vliw_link_xbar_chk #(
  .DW(DW), .NRD(NRD), .NFU(NFU), .NWR(NWR), .CW(CW),
  .OP_MASK(OP_MASK), .WR_MASK(WR_MASK), .IW(IW)
) u_chk (.*);

// File: tb/tb_vliw_link_xbar.sv
module tb_vliw_link_xbar;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;

  logic [63:0] rd_data;
  logic [47:0] fu_res;

  logic [23:0] opnd_sel;  logic [5:0] opnd_en;  logic [95:0] opnd_data;
  logic [8:0]  wr_sel;    logic [2:0] wr_en;    logic [47:0] wr_data;
  logic sel_err, cnt_clr; logic [5:0] cnt_idx;  logic [15:0] cnt_val;

  logic [23:0] t_opnd_sel; logic [5:0] t_opnd_en; logic [95:0] t_opnd_data;
  logic [8:0]  t_wr_sel;   logic [2:0] t_wr_en;   logic [47:0] t_wr_data;
  logic t_err, t_clr;      logic [5:0] t_idx;     logic [3:0]  t_cnt;

  vliw_link_xbar dut (
    .clk, .rst_n, .rd_data, .opnd_sel, .opnd_en, .opnd_data, .fu_res,
    .wr_sel, .wr_en, .wr_data, .sel_err, .cnt_clr, .cnt_idx, .cnt_val);

  vliw_link_xbar #(.CW(4), .OP_MASK(24'hFFD3FF), .WR_MASK(9'b111_001_111)) dut_trim (
    .clk, .rst_n, .rd_data, .opnd_sel(t_opnd_sel), .opnd_en(t_opnd_en),
    .opnd_data(t_opnd_data), .fu_res, .wr_sel(t_wr_sel), .wr_en(t_wr_en),
    .wr_data(t_wr_data), .sel_err(t_err), .cnt_clr(t_clr), .cnt_idx(t_idx),
    .cnt_val(t_cnt));

  // {result?, destination[2:0], source[3:0]}
  localparam logic [7:0] VEC [10] = '{8'h00, 8'h13, 8'h22, 8'h31, 8'h43,
                                      8'h50, 8'h82, 8'h90, 8'hA1, 8'h52};

  function automatic logic [15:0] rdv(int i, int r);
    return 16'(i*16'h0101 + r*16'h1000 + 1);
  endfunction
  function automatic logic [15:0] fuv(int i, int f);
    return 16'(16'hF00F - i*16'h0011 - f*16'h0200);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_pattern(int i);
    for (int r = 0; r < 4; r++) rd_data[r*16 +: 16] = rdv(i, r);
    for (int f = 0; f < 3; f++) fu_res[f*16 +: 16] = fuv(i, f);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    opnd_sel = '0; opnd_en = '0; wr_sel = '0; wr_en = '0; cnt_clr = 0; cnt_idx = 0;
    t_opnd_sel = '0; t_opnd_en = '0; t_wr_sel = '0; t_wr_en = '0; t_clr = 0; t_idx = 0;
    drive_pattern(0);
    repeat (2) @(negedge clk);
    chk("R12 err in reset", 32'(sel_err), 0);
    chk("R12 counter in reset", 32'(cnt_val), 0);
    rst_n = 1;

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      drive_pattern(i + 1);
      opnd_sel = '0; wr_sel = '0;
      if (VEC[i][7]) wr_sel = 9'(1) << (VEC[i][6:4]*3 + VEC[i][3:0]);
      else           opnd_sel = 24'(1) << (VEC[i][6:4]*4 + VEC[i][3:0]);
      #1;
      if (VEC[i][7])
        chk("R2/R3 result route", 32'(wr_data[VEC[i][6:4]*16 +: 16]), 32'(fuv(i+1, VEC[i][3:0])));
      else
        chk("R1/R3 operand route", 32'(opnd_data[VEC[i][6:4]*16 +: 16]), 32'(rdv(i+1, VEC[i][3:0])));
    end
    chk("R6 no error while disabled", 32'(sel_err), 0);

    @(negedge clk); opnd_sel = 24'(1) << 18; wr_sel = '0; opnd_en = 6'b010000;
    repeat (3) @(negedge clk);
    opnd_en = '0; cnt_idx = 18; #1;
    chk("R7 operand link count", 32'(cnt_val), 3);
    chk("R6 legal enable no error", 32'(sel_err), 0);
    cnt_idx = 17; #1;
    chk("R7 neighbour link untouched", 32'(cnt_val), 0);
    repeat (2) @(negedge clk);
    cnt_idx = 18; #1;
    chk("R8 selected but disabled", 32'(cnt_val), 3);

    @(negedge clk); wr_sel = 9'(1) << 7; wr_en = 3'b100;
    repeat (2) @(negedge clk);
    wr_en = '0; cnt_idx = 31; #1;
    chk("R7 result link count", 32'(cnt_val), 2);

    @(negedge clk); opnd_en = 6'b010000; cnt_clr = 1;
    @(negedge clk); opnd_en = '0; cnt_clr = 0; cnt_idx = 18; #1;
    chk("R10 clear beats increment", 32'(cnt_val), 0);
    cnt_idx = 31; #1;
    chk("R10 clear all links", 32'(cnt_val), 0);
    cnt_idx = 40; #1;
    chk("R11 out of range index", 32'(cnt_val), 0);

    @(negedge clk); wr_sel = 9'b000000011; wr_en = 3'b001;
    @(negedge clk); wr_en = '0; #1;
    chk("R6 non-one-hot select", 32'(sel_err), 1);
    repeat (2) @(negedge clk);
    chk("R6 error is sticky", 32'(sel_err), 1);

    t_opnd_sel = 24'(1) << 10; #1;
    chk("R4 removed operand link", 32'(t_opnd_data[2*16 +: 16]), 0);
    t_opnd_sel = 24'(1) << 9; #1;
    chk("R1 trimmed selector present link", 32'(t_opnd_data[2*16 +: 16]), 32'(rd_data[16 +: 16]));
    t_wr_sel = 9'(1) << 5; #1;
    chk("R5 single-source wire", 32'(t_wr_data[16 +: 16]), 32'(fu_res[15:0]));
    t_wr_sel = '0; #1;
    chk("R5 wire ignores empty select", 32'(t_wr_data[16 +: 16]), 32'(fu_res[15:0]));
    chk("R6 trimmed clean so far", 32'(t_err), 0);

    @(negedge clk); t_opnd_sel = 24'(1) << 10; t_opnd_en = 6'b000100;
    @(negedge clk); t_opnd_en = '0; t_idx = 10; #1;
    chk("R6 enabled removed link", 32'(t_err), 1);
    chk("R11 removed link reads zero", 32'(t_cnt), 0);

    @(negedge clk); t_opnd_sel = 24'(1); t_opnd_en = 6'b000001;
    repeat (20) @(negedge clk);
    t_opnd_en = '0; t_idx = 0; #1;
    chk("R9 saturation", 32'(t_cnt), 15);

    @(negedge clk); rst_n = 0; #1;
    chk("R12 error cleared by reset", 32'(t_err), 0);
    chk("R12 counters cleared by reset", 32'(t_cnt), 0);
    finish_run();
  end
endmodule